// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide software port of an eight-input interrupt controller. It sits between a two-address register window (one address bit, write data, read and write strobes) and the controller's datapath. Writes run a short setup sequence that can skip its optional steps, load the mask, and carry in-service clear, priority rotation, read-select, poll and special-mask commands. Reads return the request register, the in-service register, the mask, or a poll result.

The request-capture logic and the priority resolver live outside. The resolver supplies the winning request (valid plus index) and the highest-priority in-service index. This block holds the mask, the in-service register, the rotation offset, the vector base and the mode flags. It also emits a strobe when a setup sequence begins and an acknowledge strobe when a poll read takes an interrupt, so that capture logic can clear its requests.

Top module: `intc_cmd_if`

## Requirements
- R1: After reset the mask, in-service register, rotation offset, vector base and every mode flag are 0, and the setup sequence is idle.
- R2: A write to address 0 with data bit 4 set pulses `init_start` in that cycle. On the next edge it clears the mask, in-service register, offset, vector base, read select, poll, special mask and all mode flags. It latches bit 0 as "mode word follows" and bit 1 as `single_mode`, and it enters the base step.
- R3: In the base step, an address-1 write stores data[7:3] as `vec_base`. The sequence then goes to the cascade step when not single. When single, it goes to the mode step if a mode word follows, otherwise to idle. The cascade step consumes one address-1 write and goes to the mode step or to idle by the same flag.
- R4: In the mode step, an address-1 write sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, and returns to idle.
- R5: An address-1 write loads the mask only while the sequence is idle. During any other step the mask is unchanged.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms a poll. Bit 1 enables loading the read select from bit 0. Bit 6 enables loading `spec_mask` from bit 5. A field whose enable bit is clear keeps its value.
- R7: An address-0 write with bits 4 and 3 clear carries an operation in bits 7:5. Code 0 clears `rot_aeoi` and code 4 sets it. While `auto_eoi` and `rot_aeoi` are both set, a poll acknowledge of IRQ n sets the offset to (n+1) mod 8 and leaves the in-service register alone.
- R8: Code 1 clears the in-service bit at `hi_irq` when `hi_valid` is 1 and does nothing otherwise. Code 5 does the same and also sets the offset to (`hi_irq`+1) mod 8.
- R9: Code 3 clears the in-service bit given by data[2:0]. Code 7 clears that bit and sets the offset to (data[2:0]+1) mod 8.
- R10: Code 6 sets the offset to (data[2:0]+1) mod 8, so 7 gives 0.
- R11: Code 2 changes no state.
- R12: While a poll is armed, `rdata` is 0x80 OR `win_irq` when `win_valid` is 1, else 0x00. A read in that state (read strobe without write) disarms the poll. If `win_valid` was 1, the read pulses `ack_stb` with `ack_irq`=`win_irq` and acknowledges the IRQ: it sets the in-service bit when `auto_eoi` is 0.
- R13: With no poll armed, `rdata` at address 1 is the mask. At address 0 it is the in-service register when the read select is 1 and `irr_in` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| irr_in | input | 8 | Request register from capture logic |
| win_valid | input | 1 | Resolver has a winning request |
| win_irq | input | 3 | Index of the winning request |
| hi_valid | input | 1 | In-service register has a bit set |
| hi_irq | input | 3 | Highest-priority in-service index |
| rdata | output | 8 | Read data |
| imr | output | 8 | Mask register |
| isr | output | 8 | In-service register |
| prio_off | output | 3 | Rotation offset (lowest-priority index + 1) |
| vec_base | output | 5 | Vector base, bits 7:3 of the vector |
| single_mode | output | 1 | Single-controller configuration |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| spec_mask | output | 1 | Special mask mode |
| init_start | output | 1 | Setup sequence start strobe |
| ack_stb | output | 1 | Poll acknowledge strobe |
| ack_irq | output | 3 | Acknowledged IRQ index |

## Verification
The bench walks all three paths through the setup sequence: cascade with a mode word, single with a mode word, and single without one. A design that miscounted steps would load the mask from a setup word, or treat a mask write as a setup word. It wraps the offset from 7 to 0 and issues a non-specific clear with no in-service bit valid. A wrong modulo or an unguarded clear would show up as a bad offset or a lost in-service bit. It performs poll reads with and without a winner and checks the following read. A poll that never disarms or acknowledges nothing would return a stale poll byte or leave the in-service register unchanged. It also checks that rotate-on-auto-EOI moves the offset instead of setting an in-service bit.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;

  typedef enum logic [1:0] {
    INI_IDLE = 2'd0,
    INI_BASE = 2'd1,
    INI_CASC = 2'd2,
    INI_MODE = 2'd3
  } ini_st_e;

  // operation codes carried in data[7:5] of a plain command write
  typedef enum logic [2:0] {
    OP_RAEOI_OFF = 3'd0,
    OP_EOI_TOP   = 3'd1,
    OP_NONE      = 3'd2,
    OP_EOI_NUM   = 3'd3,
    OP_RAEOI_ON  = 3'd4,
    OP_EOI_TOP_R = 3'd5,
    OP_SET_LOW   = 3'd6,
    OP_EOI_NUM_R = 3'd7
  } op_e;

  // bit positions inside the command bytes
  localparam int B_SETUP   = 4;
  localparam int B_MODECMD = 3;
  localparam int B_POLL    = 2;
  localparam int B_RSEL_EN = 1;
  localparam int B_RSEL    = 0;
  localparam int B_SMM_EN  = 6;
  localparam int B_SMM     = 5;

endpackage

// File: rtl/intc_ocw_dec.sv
module intc_ocw_dec
  import intc_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IRQ_N  = 8
) (
  input  logic                      wr_en,
  input  logic                      addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic                      icw1_stb,
  output logic                      port1_wr,
  output logic                      ocw2_stb,
  output op_e                       ocw2_op,
  output logic [$clog2(IRQ_N)-1:0]  tgt_irq,
  output logic                      ocw3_stb,
  output logic                      poll_set,
  output logic                      rsel_ld,
  output logic                      rsel_val,
  output logic                      smm_ld,
  output logic                      smm_val
);
  localparam int IRQ_W = $clog2(IRQ_N);

  logic port0_wr;

  always_comb begin
    port0_wr = wr_en && !addr;
    port1_wr = wr_en && addr;
    icw1_stb = port0_wr && wdata[B_SETUP];
    ocw3_stb = port0_wr && !wdata[B_SETUP] && wdata[B_MODECMD];
    ocw2_stb = port0_wr && !wdata[B_SETUP] && !wdata[B_MODECMD];
    ocw2_op  = op_e'(wdata[DATA_W-1:DATA_W-3]);
    tgt_irq  = wdata[IRQ_W-1:0];
    poll_set = ocw3_stb && wdata[B_POLL];
    rsel_ld  = ocw3_stb && wdata[B_RSEL_EN];
    rsel_val = wdata[B_RSEL];
    smm_ld   = ocw3_stb && wdata[B_SMM_EN];
    smm_val  = wdata[B_SMM];
  end

endmodule

// File: rtl/intc_icw_seq.sv
module intc_icw_seq
  import intc_cmd_pkg::*;
#(
  parameter int BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              icw1_stb,
  input  logic              port1_wr,
  input  logic              need4_in,
  input  logic              single_in,
  input  logic [BASE_W-1:0] base_in,
  input  logic              nested_in,
  input  logic              aeoi_in,
  output ini_st_e           ini_st,
  output logic [BASE_W-1:0] vec_base,
  output logic              single_mode,
  output logic              nested_mode,
  output logic              auto_eoi,
  output logic              mask_ld
);
  logic need4_q;

  // step that follows the base word: the cascade word is skipped when single
  function automatic ini_st_e after_base(input logic single, input logic need4);
    if (!single) return INI_CASC;
    return need4 ? INI_MODE : INI_IDLE;
  endfunction

  assign mask_ld = port1_wr && (ini_st == INI_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ini_st      <= INI_IDLE;
      need4_q     <= 1'b0;
      vec_base    <= '0;
      single_mode <= 1'b0;
      nested_mode <= 1'b0;
      auto_eoi    <= 1'b0;
    end else if (icw1_stb) begin
      ini_st      <= INI_BASE;
      need4_q     <= need4_in;
      single_mode <= single_in;
      vec_base    <= '0;
      nested_mode <= 1'b0;
      auto_eoi    <= 1'b0;
    end else if (port1_wr) begin
      case (ini_st)
        INI_BASE: begin
          vec_base <= base_in;
          ini_st   <= after_base(single_mode, need4_q);
        end
        INI_CASC: ini_st <= need4_q ? INI_MODE : INI_IDLE;
        INI_MODE: begin
          nested_mode <= nested_in;
          auto_eoi    <= aeoi_in;
          ini_st      <= INI_IDLE;
        end
        default: ini_st <= INI_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/intc_isr_ctl.sv
module intc_isr_ctl
  import intc_cmd_pkg::*;
#(
  parameter int IRQ_N = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      icw1_stb,
  input  logic                      ocw2_stb,
  input  op_e                       ocw2_op,
  input  logic [$clog2(IRQ_N)-1:0]  tgt_irq,
  input  logic                      poll_set,
  input  logic                      rsel_ld,
  input  logic                      rsel_val,
  input  logic                      smm_ld,
  input  logic                      smm_val,
  input  logic                      hi_valid,
  input  logic [$clog2(IRQ_N)-1:0]  hi_irq,
  input  logic                      poll_rd,
  input  logic                      win_valid,
  input  logic [$clog2(IRQ_N)-1:0]  win_irq,
  input  logic                      auto_eoi,
  output logic [IRQ_N-1:0]          isr,
  output logic [$clog2(IRQ_N)-1:0]  prio_off,
  output logic                      rot_aeoi,
  output logic                      poll_q,
  output logic                      rsel_q,
  output logic                      smm_q,
  output logic                      ack_stb
);
  localparam int IRQ_W = $clog2(IRQ_N);

  // offset that makes IRQ n the lowest priority; wraps modulo IRQ_N
  function automatic logic [IRQ_W-1:0] off_after(input logic [IRQ_W-1:0] n);
    return n + 1'b1;
  endfunction

  function automatic logic [IRQ_N-1:0] irq_bit(input logic [IRQ_W-1:0] n);
    logic [IRQ_N-1:0] v;
    v    = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  // named internal events
  logic             clr_stb;
  logic [IRQ_W-1:0] clr_irq;
  logic             off_ld;
  logic [IRQ_W-1:0] off_val;
  logic             ack_set;
  logic             raeoi_ld;

  always_comb begin
    clr_stb  = 1'b0;
    clr_irq  = hi_irq;
    off_ld   = 1'b0;
    off_val  = off_after(hi_irq);
    raeoi_ld = 1'b0;
    ack_stb  = poll_q && poll_rd && win_valid;
    ack_set  = ack_stb && !auto_eoi;
    if (ocw2_stb) begin
      case (ocw2_op)
        OP_RAEOI_OFF, OP_RAEOI_ON: raeoi_ld = 1'b1;
        OP_EOI_TOP:   clr_stb = hi_valid;
        OP_EOI_TOP_R: begin
          clr_stb = hi_valid;
          off_ld  = hi_valid;
        end
        OP_EOI_NUM: begin
          clr_stb = 1'b1;
          clr_irq = tgt_irq;
        end
        OP_SET_LOW: begin
          off_ld  = 1'b1;
          off_val = off_after(tgt_irq);
        end
        OP_EOI_NUM_R: begin
          clr_stb = 1'b1;
          clr_irq = tgt_irq;
          off_ld  = 1'b1;
          off_val = off_after(tgt_irq);
        end
        default: ;
      endcase
    end else if (ack_stb && auto_eoi && rot_aeoi) begin
      off_ld  = 1'b1;
      off_val = off_after(win_irq);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr      <= '0;
      prio_off <= '0;
      rot_aeoi <= 1'b0;
      poll_q   <= 1'b0;
      rsel_q   <= 1'b0;
      smm_q    <= 1'b0;
    end else if (icw1_stb) begin
      isr      <= '0;
      prio_off <= '0;
      rot_aeoi <= 1'b0;
      poll_q   <= 1'b0;
      rsel_q   <= 1'b0;
      smm_q    <= 1'b0;
    end else begin
      isr <= (isr & ~(clr_stb ? irq_bit(clr_irq) : '0))
           | (ack_set ? irq_bit(win_irq) : '0);
      if (off_ld)   prio_off <= off_val;
      if (raeoi_ld) rot_aeoi <= (ocw2_op == OP_RAEOI_ON);
      if (poll_set) poll_q <= 1'b1;
      else if (poll_q && poll_rd) poll_q <= 1'b0;
      if (rsel_ld)  rsel_q <= rsel_val;
      if (smm_ld)   smm_q  <= smm_val;
    end
  end

endmodule

// File: rtl/intc_cmd_if.sv
module intc_cmd_if
  import intc_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IRQ_N  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [IRQ_N-1:0]          irr_in,
  input  logic                      win_valid,
  input  logic [$clog2(IRQ_N)-1:0]  win_irq,
  input  logic                      hi_valid,
  input  logic [$clog2(IRQ_N)-1:0]  hi_irq,
  output logic [DATA_W-1:0]         rdata,
  output logic [IRQ_N-1:0]          imr,
  output logic [IRQ_N-1:0]          isr,
  output logic [$clog2(IRQ_N)-1:0]  prio_off,
  output logic [DATA_W-$clog2(IRQ_N)-1:0] vec_base,
  output logic                      single_mode,
  output logic                      nested_mode,
  output logic                      auto_eoi,
  output logic                      rot_aeoi,
  output logic                      spec_mask,
  output logic                      init_start,
  output logic                      ack_stb,
  output logic [$clog2(IRQ_N)-1:0]  ack_irq
);
  localparam int IRQ_W  = $clog2(IRQ_N);
  localparam int BASE_W = DATA_W - IRQ_W;

  function automatic logic [DATA_W-1:0] poll_byte(input logic hit, input logic [IRQ_W-1:0] n);
    logic [DATA_W-1:0] v;
    v = '0;
    if (hit) begin
      v[DATA_W-1]  = 1'b1;
      v[IRQ_W-1:0] = n;
    end
    return v;
  endfunction

  logic             icw1_stb, port1_wr, ocw2_stb, ocw3_stb;
  op_e              ocw2_op;
  logic [IRQ_W-1:0] tgt_irq;
  logic             poll_set, rsel_ld, rsel_val, smm_ld, smm_val;
  logic             mask_ld, poll_q, rsel_q, poll_rd;
  ini_st_e          ini_st;
  logic [1:0]       init_st;

  assign init_st    = ini_st;
  assign init_start = icw1_stb;
  assign poll_rd    = rd_en && !wr_en;
  assign ack_irq    = win_irq;

  intc_ocw_dec #(.DATA_W(DATA_W), .IRQ_N(IRQ_N)) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .icw1_stb(icw1_stb), .port1_wr(port1_wr), .ocw2_stb(ocw2_stb),
    .ocw2_op(ocw2_op), .tgt_irq(tgt_irq), .ocw3_stb(ocw3_stb),
    .poll_set(poll_set), .rsel_ld(rsel_ld), .rsel_val(rsel_val),
    .smm_ld(smm_ld), .smm_val(smm_val)
  );

  intc_icw_seq #(.BASE_W(BASE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .icw1_stb(icw1_stb), .port1_wr(port1_wr),
    .need4_in(wdata[0]), .single_in(wdata[1]),
    .base_in(wdata[DATA_W-1:IRQ_W]), .nested_in(wdata[4]), .aeoi_in(wdata[1]),
    .ini_st(ini_st), .vec_base(vec_base), .single_mode(single_mode),
    .nested_mode(nested_mode), .auto_eoi(auto_eoi), .mask_ld(mask_ld)
  );

  intc_isr_ctl #(.IRQ_N(IRQ_N)) u_isr (
    .clk(clk), .rst_n(rst_n), .icw1_stb(icw1_stb), .ocw2_stb(ocw2_stb),
    .ocw2_op(ocw2_op), .tgt_irq(tgt_irq), .poll_set(poll_set),
    .rsel_ld(rsel_ld), .rsel_val(rsel_val), .smm_ld(smm_ld), .smm_val(smm_val),
    .hi_valid(hi_valid), .hi_irq(hi_irq), .poll_rd(poll_rd),
    .win_valid(win_valid), .win_irq(win_irq), .auto_eoi(auto_eoi),
    .isr(isr), .prio_off(prio_off), .rot_aeoi(rot_aeoi), .poll_q(poll_q),
    .rsel_q(rsel_q), .smm_q(spec_mask), .ack_stb(ack_stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        imr <= '0;
    else if (icw1_stb) imr <= '0;
    else if (mask_ld)  imr <= wdata[IRQ_N-1:0];
  end

  always_comb begin
    if (poll_q)      rdata = poll_byte(win_valid, win_irq);
    else if (addr)   rdata = DATA_W'(imr);
    else if (rsel_q) rdata = DATA_W'(isr);
    else             rdata = DATA_W'(irr_in);
  end

endmodule

// File: rtl/intc_cmd_if_chk.sv
module intc_cmd_if_chk #(
  parameter int DATA_W = 8,
  parameter int IRQ_N  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic                      addr,
  input logic [DATA_W-1:0]         wdata,
  input logic [IRQ_N-1:0]          imr,
  input logic [IRQ_N-1:0]          isr,
  input logic [$clog2(IRQ_N)-1:0]  prio_off,
  input logic [1:0]                init_st,
  input logic                      poll_q,
  input logic                      ack_stb
);
  localparam int IRQ_W = $clog2(IRQ_N);

  assert_init_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (imr == '0 && isr == '0 && prio_off == '0 && init_st == 2'd1));

  assert_mask_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && init_st != 2'd0) |=> $stable(imr));

  assert_mode_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && init_st == 2'd3) |=> (init_st == 2'd0));

  assert_low_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4:3] == 2'b00 && wdata[7:5] == 3'd6)
      |=> (prio_off == IRQ_W'($past(wdata[IRQ_W-1:0]) + 1'b1)));

  assert_poll_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && poll_q) |=> !poll_q);

  assert_ack_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> (poll_q && rd_en && !wr_en));

endmodule

bind intc_cmd_if intc_cmd_if_chk #(.DATA_W(DATA_W), .IRQ_N(IRQ_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .imr(imr), .isr(isr), .prio_off(prio_off),
  .init_st(init_st), .poll_q(poll_q), .ack_stb(ack_stb)
);

// File: tb/sim_intc_cmd_if.sv
`timescale 1ns/1ps
module sim_intc_cmd_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, irr_in = '0;
  logic       win_valid = 1'b0, hi_valid = 1'b0;
  logic [2:0] win_irq = '0, hi_irq = '0;
  logic [7:0] rdata, imr, isr;
  logic [2:0] prio_off, ack_irq;
  logic [4:0] vec_base;
  logic       single_mode, nested_mode, auto_eoi, rot_aeoi, spec_mask, init_start, ack_stb;

  int errors = 0, checks = 0;
  bit cmp_on = 0, done = 0;

  always #2 clk = ~clk;

  intc_cmd_if u0 (.*);

  // behavioural reference state
  int m_st, m_n4, m_sg, m_imr, m_isr, m_off, m_vb, m_nf, m_ae, m_ra, m_rs, m_pl, m_sm;

  task automatic m_clear();
    m_st = 0; m_n4 = 0; m_sg = 0; m_imr = 0; m_isr = 0; m_off = 0; m_vb = 0;
    m_nf = 0; m_ae = 0; m_ra = 0; m_rs = 0; m_pl = 0; m_sm = 0;
  endtask

  initial m_clear();

  always @(posedge clk) begin
    int d, op;
    d = wdata;
    op = d / 32;
    if (!rst_n) m_clear();
    else if (wr_en) begin
      if (!addr) begin
        if (d[4]) begin
          m_clear(); m_n4 = d[0]; m_sg = d[1]; m_st = 1;
        end else if (d[3]) begin
          if (d[2]) m_pl = 1;
          if (d[1]) m_rs = d[0];
          if (d[6]) m_sm = d[5];
        end else begin
          if (op == 0) m_ra = 0;
          if (op == 4) m_ra = 1;
          if ((op == 1 || op == 5) && hi_valid) begin
            m_isr = m_isr & ~(1 << hi_irq);
            if (op == 5) m_off = (hi_irq + 1) % 8;
          end
          if (op == 3 || op == 7) m_isr = m_isr & ~(1 << (d % 8));
          if (op == 6 || op == 7) m_off = (d % 8 + 1) % 8;
        end
      end else begin
        if (m_st == 0) m_imr = d;
        else if (m_st == 1) begin
          m_vb = d / 8;
          m_st = !m_sg ? 2 : (m_n4 ? 3 : 0);
        end else if (m_st == 2) m_st = m_n4 ? 3 : 0;
        else begin
          m_nf = d[4]; m_ae = d[1]; m_st = 0;
        end
      end
    end else if (rd_en && m_pl != 0) begin
      if (win_valid) begin
        if (m_ae == 0) m_isr = m_isr | (1 << win_irq);
        else if (m_ra != 0) m_off = (win_irq + 1) % 8;
      end
      m_pl = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int m_rdata();
    if (m_pl != 0) return win_valid ? (128 + win_irq) : 0;
    if (addr) return m_imr;
    return m_rs != 0 ? m_isr : irr_in;
  endfunction

  // compare every output against the model once per cycle
  always @(negedge clk) if (cmp_on) begin
    chk("R5", "imr", imr, m_imr);
    chk("R8", "isr", isr, m_isr);
    chk("R10", "prio_off", prio_off, m_off);
    chk("R3", "vec_base", vec_base, m_vb);
    chk("R2", "single_mode", single_mode, m_sg);
    chk("R4", "nested_mode", nested_mode, m_nf);
    chk("R4", "auto_eoi", auto_eoi, m_ae);
    chk("R7", "rot_aeoi", rot_aeoi, m_ra);
    chk("R6", "spec_mask", spec_mask, m_sm);
    chk("R2", "init_start", init_start, int'(wr_en && !addr && wdata[4]));
    chk("R13", "rdata", rdata, m_rdata());
    chk("R12", "ack_stb", ack_stb, int'(m_pl != 0 && rd_en && !wr_en && win_valid));
    if (ack_stb) chk("R12", "ack_irq", ack_irq, win_irq);
  end

  task automatic cyc(input logic w, input logic r, input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask
  task automatic idle(); cyc(0, 0, 0, 8'h00); endtask
  task automatic wr0(input logic [7:0] d); cyc(1, 0, 0, d); endtask
  task automatic wr1(input logic [7:0] d); cyc(1, 0, 1, d); endtask
  task automatic settle(); idle(); @(negedge clk); endtask
  task automatic poll_take(input logic [2:0] n);
    win_valid = 1; win_irq = n;
    wr0(8'h0C); cyc(0, 1, 0, 8'h00); settle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL all watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1;
    // R1 reset state
    cyc(0, 1, 1, 8'h00); @(negedge clk);
    chk("R1", "rdata addr1", rdata, 0);
    chk("R1", "imr/isr/off/base", {imr, isr, prio_off, vec_base}, 0);
    chk("R1", "flags", {single_mode, nested_mode, auto_eoi, rot_aeoi, spec_mask}, 0);
    // R3 cascade path with mode word, R4 mode word
    wr0(8'h11); wr1(8'h48); wr1(8'h04); wr1(8'h12); wr1(8'hA5); settle();
    chk("R3", "base cascade", vec_base, 9);
    chk("R4", "nested/aeoi", {nested_mode, auto_eoi}, 2'b11);
    chk("R5", "mask after setup", imr, 8'hA5);
    // R2 clear on start; single path with mode word
    wr0(8'h13); settle();
    chk("R2", "imr cleared", imr, 0);
    chk("R2", "single latched", single_mode, 1);
    wr1(8'h20); wr1(8'h00); wr1(8'h3C); settle();
    chk("R3", "single+mode mask", imr, 8'h3C);
    chk("R4", "aeoi off", auto_eoi, 0);
    // single path without mode word
    wr0(8'h12); wr1(8'h08); wr1(8'h55); settle();
    chk("R3", "single skip mask", imr, 8'h55);
    chk("R3", "single skip base", vec_base, 1);
    // R12 poll with winner
    win_valid = 1; win_irq = 5;
    wr0(8'h0C); cyc(0, 1, 0, 8'h00); @(negedge clk);
    chk("R12", "poll byte", rdata, 8'h85);
    chk("R12", "ack", {ack_stb, ack_irq}, {1'b1, 3'd5});
    settle();
    chk("R12", "isr set by ack", isr, 8'h20);
    cyc(0, 1, 1, 8'h00); @(negedge clk);
    chk("R13", "mask read after poll", rdata, 8'h55);
    // R13 read select
    wr0(8'h0B); cyc(0, 1, 0, 8'h00); @(negedge clk);
    chk("R13", "isr read", rdata, 8'h20);
    irr_in = 8'h99;
    wr0(8'h0A); cyc(0, 1, 0, 8'h00); @(negedge clk);
    chk("R13", "irr read", rdata, 8'h99);
    // R6 read-select enable clear keeps value
    wr0(8'h09); cyc(0, 1, 0, 8'h00); @(negedge clk);
    chk("R6", "rsel kept", rdata, 8'h99);
    // poll with nothing pending
    win_valid = 0;
    wr0(8'h0C); cyc(0, 1, 0, 8'h00); @(negedge clk);
    chk("R12", "empty poll", rdata, 0);
    settle();
    chk("R12", "isr kept", isr, 8'h20);
    // R9 specific clears
    wr0(8'h65); settle();
    chk("R9", "specific clear", isr, 0);
    poll_take(3); poll_take(6);
    chk("R12", "two acks", isr, 8'h48);
    wr0(8'hE6); settle();
    chk("R9", "clear+rotate isr", isr, 8'h08);
    chk("R9", "clear+rotate off", prio_off, 7);
    // R8 non-specific clears
    hi_valid = 1; hi_irq = 3;
    wr0(8'h20); settle();
    chk("R8", "top clear", isr, 0);
    poll_take(2);
    hi_valid = 0;
    wr0(8'h20); settle();
    chk("R8", "no top no clear", isr, 8'h04);
    hi_valid = 1; hi_irq = 2;
    wr0(8'hA0); settle();
    chk("R8", "top clear rotate", {isr, prio_off}, {8'h00, 3'd3});
    // R10 offset wrap
    wr0(8'hC7); settle();
    chk("R10", "offset wrap", prio_off, 0);
    wr0(8'hC2); settle();
    chk("R10", "offset set", prio_off, 3);
    // R11 unused code
    poll_take(1);
    wr0(8'h41); settle();
    chk("R11", "nop code", {isr, prio_off}, {8'h02, 3'd3});
    // R7 rotate on automatic EOI
    wr0(8'h11); wr1(8'h00); wr1(8'h00); wr1(8'h02); settle();
    wr0(8'h80); settle();
    chk("R7", "raeoi set", rot_aeoi, 1);
    poll_take(4);
    chk("R7", "aeoi rotate", {isr, prio_off}, {8'h00, 3'd5});
    wr0(8'h00); settle();
    chk("R7", "raeoi clear", rot_aeoi, 0);
    poll_take(6);
    chk("R7", "aeoi no rotate", {isr, prio_off}, {8'h00, 3'd5});
    // R6 special mask
    wr0(8'h68); settle();
    chk("R6", "smm set", spec_mask, 1);
    wr0(8'h28); settle();
    chk("R6", "smm kept", spec_mask, 1);
    wr0(8'h48); settle();
    chk("R6", "smm clear", spec_mask, 0);
    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      wr_en = ($urandom_range(0, 2) == 0);
      rd_en = ($urandom_range(0, 2) == 0);
      addr = $urandom_range(0, 1);
      wdata = ($urandom_range(0, 5) == 0) ? 8'h0C : 8'($urandom);
      if (!addr && wdata[4] && $urandom_range(0, 3) != 0) wdata[4] = 1'b0;
      irr_in = 8'($urandom);
      win_valid = $urandom_range(0, 1); win_irq = 3'($urandom);
      hi_valid = $urandom_range(0, 1); hi_irq = 3'($urandom);
    end
    settle();
    done = 1;
    summary();
    $finish;
  end

endmodule